// File: doc/BRIEF.md
# Multi-Channel Pulse-Density Modulator Bank

This block drives a bank of single-bit outputs whose average level follows a programmable duty word per channel. Each channel holds a phase accumulator; on every clock it adds its duty word to the accumulator and emits the carry of that addition as its output bit. The low bits of the sum go back into the accumulator. The result is first-order pulse-density modulation. High and low cycles are spread as evenly as the duty word allows, which suits RC-filtered analog levels or current set-points for microstepping drivers.

Software, or a neighbouring controller, loads duty words through a plain address/data/write-enable port, with one register per channel. Channel count and duty width are parameters. Each channel costs one adder, one accumulator register and one duty register, so the bank grows to around a hundred outputs without change. Reset is applied asynchronously and released in step with the clock through a two-stage synchronizer.

Top module: `pdm_bank`

## Requirements
- R1: While `rst_n` is low, every output is low, and all duty words and accumulators are cleared. After `rst_n` rises, outputs stay low until a non-zero duty word is written.
- R2: When `wr_en` is high at a rising clock edge and `wr_addr` is below NUM_CH, the duty register of channel `wr_addr` takes `wr_data` at that edge. No other channel's register changes.
- R3: On every clock, each channel forms the DUTY_W+1-bit sum of its accumulator and duty word. It registers the top bit of that sum as its output and keeps the low DUTY_W bits as the new accumulator.
- R4: With a constant duty word D, any 2^DUTY_W consecutive output cycles of a channel contain exactly D high cycles.
- R5: A duty word of 0 holds the channel output low on every cycle.
- R6: A duty word of all ones (2^DUTY_W - 1) gives exactly one low cycle in every window of 2^DUTY_W cycles, and never two low cycles in a row.
- R7: A written duty word is used by the accumulator update at the clock edge right after the write edge. A write never clears or reloads the accumulator, so the phase carries on.
- R8: Channels are independent: each channel's density depends only on its own duty word.
- R9: A write with `wr_addr` at or above NUM_CH changes no duty register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Duty register write strobe |
| wr_addr | input | max(1, clog2(NUM_CH)) | Channel index for the write |
| wr_data | input | DUTY_W | Duty word to store |
| pdm_out | output | NUM_CH | Pulse-density output, one bit per channel |

## Verification
The bench builds the bank with five channels and a 6-bit duty word. A full density period is then only 64 cycles, so exact high-cycle counts can be checked over whole periods for several duty sets, including 0, 1, half scale and all ones. Five channels with a 3-bit address leave three addresses with no channel behind them, so ignored writes can be observed. The small width also makes the accumulator phase predictable from reset, which lets the bench tell a write that keeps the phase apart from one that clears it or takes effect late.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

  // address width for a bank of n channels, never below one bit
  function automatic int unsigned sel_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pdm_rst_sync.sv
module pdm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/pdm_duty_file.sv
module pdm_duty_file #(
  parameter int unsigned NUM_CH = 96,
  parameter int unsigned DUTY_W = 10,
  parameter int unsigned ADDR_W = 7
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DUTY_W-1:0]                wr_data,
  output logic [NUM_CH-1:0][DUTY_W-1:0]    duty_o
);

  logic [NUM_CH-1:0] load_en;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slot
    logic [DUTY_W-1:0] duty_q;

    always_comb begin
      load_en[ch] = wr_en && (wr_addr == ADDR_W'(ch));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        duty_q <= '0;
      end else if (load_en[ch]) begin
        duty_q <= wr_data;
      end
    end

    assign duty_o[ch] = duty_q;
  end

  // R2: an in-range write lands in the addressed slot
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_addr) < int'(NUM_CH))) |=> (duty_o[$past(wr_addr)] == $past(wr_data)));

  // R9: a write beyond the last channel leaves every slot untouched
  p_ignore_oob_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_addr) >= int'(NUM_CH))) |=> $stable(duty_o));

endmodule

// File: rtl/pdm_channel.sv
module pdm_channel #(
  parameter int unsigned DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pdm_o
);

  localparam logic [DUTY_W-1:0] FULL = {DUTY_W{1'b1}};

  logic [DUTY_W-1:0] acc_q;
  logic [DUTY_W-1:0] acc_d;
  logic              out_q;
  logic              out_d;
  logic [DUTY_W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, duty_i};
    acc_d = sum[DUTY_W-1:0];
    out_d = sum[DUTY_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      out_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      out_q <= out_d;
    end
  end

  assign pdm_o = out_q;

  // R5: a zero duty word never produces a high output
  p_zero_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i == '0) |=> !pdm_o);

  // R6: at full scale a low cycle is always followed by a high one
  p_full_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pdm_o && (duty_i == FULL) && ($past(duty_i) == FULL)) |=> pdm_o);

endmodule

// File: rtl/pdm_bank.sv
module pdm_bank #(
  parameter int unsigned NUM_CH = 96,
  parameter int unsigned DUTY_W = 10,
  parameter int unsigned ADDR_W = pdm_pkg::sel_width(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DUTY_W-1:0] wr_data,
  output logic [NUM_CH-1:0] pdm_out
);

  logic                          rst_n_int;
  logic [NUM_CH-1:0][DUTY_W-1:0] duty;

  pdm_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pdm_duty_file #(
    .NUM_CH (NUM_CH),
    .DUTY_W (DUTY_W),
    .ADDR_W (ADDR_W)
  ) u_duty_file (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .duty_o  (duty)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    pdm_channel #(
      .DUTY_W (DUTY_W)
    ) u_chan (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .duty_i (duty[ch]),
      .pdm_o  (pdm_out[ch])
    );
  end

  // R1: outputs are held low while the internal reset is active
  p_reset_low_r1: assert property (@(posedge clk)
    (!rst_n_int && !$isunknown(rst_n_int)) |-> (pdm_out == '0));

endmodule

// File: tb/pdm_bank_tb_top.sv
module pdm_bank_tb_top;

  localparam int NCH    = 5;
  localparam int W      = 6;
  localparam int AW     = 3;
  localparam int PERIOD = 1 << W;

  logic           clk;
  logic           rst_n;
  logic           wr_en;
  logic [AW-1:0]  wr_addr;
  logic [W-1:0]   wr_data;
  logic [NCH-1:0] pdm_out;

  int total_checks;
  int failed_checks;
  int cycles;
  int exp_duty [NCH];
  int cnt [NCH];
  bit done;

  pdm_bank #(.NUM_CH(NCH), .DUTY_W(W)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pdm_out (pdm_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", total_checks - failed_checks, total_checks);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        total_checks++;
        failed_checks++;
        $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
        summary();
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total_checks++;
    if (!ok) begin
      failed_checks++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic write_duty(input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = AW'(addr);
    wr_data = W'(data);
    @(negedge clk);
    wr_en   = 1'b0;
    if (addr < NCH) exp_duty[addr] = data;
  endtask

  // R1: reset drives outputs low at once and clears duty words
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(pdm_out == '0, "R1 outputs low in reset", int'(pdm_out), 0);
    repeat (3) @(negedge clk);
    check(pdm_out == '0, "R1 outputs low held in reset", int'(pdm_out), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NCH; i++) exp_duty[i] = 0;
  endtask

  // counts high cycles of every channel over one full period
  task automatic count_period(input string tag);
    for (int i = 0; i < NCH; i++) cnt[i] = 0;
    for (int t = 0; t < PERIOD; t++) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) if (pdm_out[i]) cnt[i]++;
    end
    for (int i = 0; i < NCH; i++)
      check(cnt[i] == exp_duty[i], tag, cnt[i], exp_duty[i]);
  endtask

  task automatic t_after_reset();
    do_reset();
    count_period("R1 zero density after reset");
  endtask

  // R4 R5 R6 R8: fixed duty set with the corner values
  task automatic t_fixed_set();
    int lows;
    int run_low;
    bit double_low;
    write_duty(0, 0);
    write_duty(1, 1);
    write_duty(2, PERIOD - 1);
    write_duty(3, PERIOD / 2);
    write_duty(4, 45);
    lows = 0;
    double_low = 1'b0;
    run_low = 0;
    for (int i = 0; i < NCH; i++) cnt[i] = 0;
    for (int t = 0; t < PERIOD; t++) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) if (pdm_out[i]) cnt[i]++;
      if (!pdm_out[2]) begin
        lows++;
        run_low++;
        if (run_low > 1) double_low = 1'b1;
      end else begin
        run_low = 0;
      end
      if (pdm_out[0]) double_low = double_low;
    end
    check(cnt[0] == 0, "R5 zero duty stays low", cnt[0], 0);
    check(cnt[1] == 1, "R4 duty one density", cnt[1], 1);
    check(lows == 1, "R6 full scale one low per period", lows, 1);
    check(!double_low, "R6 no two lows in a row", int'(double_low), 0);
    check(cnt[3] == PERIOD / 2, "R4 half scale density", cnt[3], PERIOD / 2);
    check(cnt[4] == 45, "R8 independent channel density", cnt[4], 45);
  endtask

  // R4 R8: pseudo-random duty sets
  task automatic t_random_sets();
    int seed;
    seed = 7;
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < NCH; i++) begin
        seed = (seed * 37 + 11) % 1024;
        write_duty(i, seed % PERIOD);
      end
      count_period("R4 R8 random duty density");
    end
  endtask

  // R9: writes past the last channel change nothing
  task automatic t_out_of_range();
    for (int a = NCH; a < (1 << AW); a++) write_duty(a, 13 + a);
    count_period("R9 out-of-range write ignored");
  endtask

  // R2 R7: new duty applies on the next update and keeps the phase
  task automatic t_phase_keep();
    int tries;
    do_reset();
    write_duty(0, PERIOD / 2);
    tries = 0;
    do begin
      @(negedge clk);
      tries++;
    end while (!pdm_out[0] && tries < 8);
    check(pdm_out[0] == 1'b1, "R3 half scale carry appears", int'(pdm_out[0]), 1);
    wr_en   = 1'b1;
    wr_addr = '0;
    wr_data = W'(PERIOD / 4);
    @(negedge clk);
    wr_en = 1'b0;
    exp_duty[0] = PERIOD / 4;
    check(pdm_out[0] == 1'b0, "R7 first update after write", int'(pdm_out[0]), 0);
    @(negedge clk);
    check(pdm_out[0] == 1'b0, "R7 second update uses new duty", int'(pdm_out[0]), 0);
    @(negedge clk);
    check(pdm_out[0] == 1'b1, "R7 phase kept across write", int'(pdm_out[0]), 1);
    count_period("R2 written duty density");
  endtask

  initial begin
    total_checks  = 0;
    failed_checks = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    for (int i = 0; i < NCH; i++) exp_duty[i] = 0;
    repeat (2) @(negedge clk);
    t_after_reset();
    t_fixed_set();
    t_random_sets();
    t_out_of_range();
    t_phase_keep();
    t_after_reset();
    done = 1'b1;
    summary();
  end

endmodule